// File: doc/BRIEF.md
# Keyed One-Shot Watchdog Timer

This block is a watchdog that stays dormant after reset until software writes a two-byte unlock key to a single write-only register. The same key, written again later, restarts the count. Once armed, the watchdog cannot be switched off by software. Only a hardware reset or its own expiry ends it.

While armed, a counter advances on each machine-cycle tick. It pauses while the device is powered down. After a power-down that an external interrupt ends, it stays paused for as long as that interrupt line is held low. A configuration bit can also pause it during idle. When the counter runs past its top value, the block raises a one-cycle device reset request and clears itself. Unless a configuration bit suppresses it, the block also drives a reset-out pulse of fixed length, counted in oscillator clocks.

The block is clocked by the oscillator clock. The machine-cycle tick comes from the surrounding clock divider. Register writes arrive as a strobe with an address and a data byte.

Top module: `wdk_top`

## Requirements
- R1: After a synchronous reset, `wd_reset_req` and `wd_rst_out` are low and the watchdog is disarmed, so ticks alone never produce a reset request. Asserting `rst` while the watchdog is armed disarms it.
- R2: Writing 0x1E and then 0x E1 to address 0xA6 arms the watchdog with a count of zero. Writes to any other address between the two bytes are ignored and do not break the sequence.
- R3: Writing the key again while the watchdog is armed clears the count. The next expiry then comes 2^CNT_W counted ticks after the second key byte.
- R4: An 0xE1 write to 0xA6 that does not directly follow an 0x1E write to 0xA6 has no effect. Any other byte written to 0xA6 after 0x1E returns the key sequence to its start, and that includes a second 0x1E.
- R5: Once armed, the watchdog expires on the 2^CNT_W-th counted tick. `wd_reset_req` is high for exactly one clock, one clock after that tick. The watchdog is then disarmed.
- R6: On expiry, `wd_rst_out` rises in the same clock as `wd_reset_req` and stays high for exactly RSTOUT_LEN clocks.
- R7: With `cfg_rstout_off` high, expiry still raises `wd_reset_req`, but `wd_rst_out` stays low.
- R8: While `pd_active` is high, ticks are not counted.
- R9: If `wake_irq_low` is high when power-down ends, counting stays frozen until `wake_irq_low` goes low.
- R10: While `idle_active` is high, ticks are counted if `cfg_pause_idle` is 0 and ignored if it is 1.
- R11: Once the watchdog is armed, no register write can disarm it.
- R12: If the second key byte and the expiring tick arrive in the same clock, the key wins. No reset request is raised, and counting restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| mc_tick | input | 1 | One-clock pulse per machine cycle |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 8 | Register write address |
| reg_wr_data | input | 8 | Register write data |
| pd_active | input | 1 | Device is in power-down |
| idle_active | input | 1 | Device is in idle |
| wake_irq_low | input | 1 | Wake-up interrupt line is held at its active low level |
| cfg_pause_idle | input | 1 | 1 pauses counting during idle |
| cfg_rstout_off | input | 1 | 1 suppresses the reset-out pulse |
| wd_reset_req | output | 1 | One-clock device reset request on expiry |
| wd_rst_out | output | 1 | Reset-out pulse, RSTOUT_LEN clocks long |

## Verification
The bench builds the block with CNT_W = 6 and RSTOUT_LEN = 12. With these values an expiry takes only 64 counted ticks, so each scenario can count every tick to the exact expiry index, including the frozen stretches of power-down, wake hold and idle. The shorter pulse lets the bench measure the whole reset-out width clock by clock. The bench also places the key byte on the very tick that would expire the counter. The key address and key bytes keep their defaults.

// File: rtl/wdk_pkg.sv
package wdk_pkg;

    typedef enum logic {
        KEY_IDLE  = 1'b0,
        KEY_ARMED = 1'b1
    } key_state_e;

    typedef struct packed {
        logic       wr;
        logic [7:0] addr;
        logic [7:0] data;
    } reg_wr_t;

    typedef struct packed {
        logic pd;
        logic idle;
        logic pause_idle;
        logic wake_low;
    } pwr_ctx_t;

    // Counting is allowed unless powered down, held after wake, or paused in idle.
    function automatic logic count_allowed(input pwr_ctx_t ctx, input logic hold);
        return !ctx.pd && !hold && !(ctx.idle && ctx.pause_idle);
    endfunction

endpackage

// File: rtl/wdk_key_fsm.sv
module wdk_key_fsm
    import wdk_pkg::*;
#(
    parameter logic [7:0] KEY_ADDR   = 8'hA6,
    parameter logic [7:0] KEY_FIRST  = 8'h1E,
    parameter logic [7:0] KEY_SECOND = 8'hE1
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    clr,
    input  reg_wr_t wr,
    output logic    service_stb
);

    key_state_e state_q, state_d;
    logic       hit;

    assign hit = wr.wr && (wr.addr == KEY_ADDR);

    always_comb begin
        state_d     = state_q;
        service_stb = 1'b0;
        if (hit) begin
            unique case (state_q)
                KEY_IDLE: begin
                    if (wr.data == KEY_FIRST) state_d = KEY_ARMED;
                end
                KEY_ARMED: begin
                    state_d = KEY_IDLE;
                    if (wr.data == KEY_SECOND) service_stb = 1'b1;
                end
                default: state_d = KEY_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) state_q <= KEY_IDLE;
        else            state_q <= state_d;
    end

    // R4: a completed key always comes from the armed state
    p_key_needs_first_r4: assert property (@(posedge clk) disable iff (rst)
        service_stb |-> (state_q == KEY_ARMED));

    // R2: writes to other addresses leave the sequence untouched
    p_other_addr_ignored_r2: assert property (@(posedge clk) disable iff (rst)
        (wr.wr && wr.addr != KEY_ADDR && !clr) |=> $stable(state_q));

endmodule

// File: rtl/wdk_counter.sv
module wdk_counter
    import wdk_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     service,
    input  pwr_ctx_t pwr,
    output logic     ovf_stb,
    output logic     armed,
    output logic     reset_req
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic             en_q;
    logic             hold_q;
    logic             req_q;
    logic             run;

    assign run     = en_q && count_allowed(pwr, hold_q);
    assign ovf_stb = run && tick && (cnt_q == CNT_MAX) && !service;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            en_q   <= 1'b0;
            hold_q <= 1'b0;
            req_q  <= 1'b0;
        end else begin
            hold_q <= pwr.wake_low && (pwr.pd || hold_q);
            req_q  <= ovf_stb;
            if (service) begin
                en_q  <= 1'b1;
                cnt_q <= '0;
            end else if (ovf_stb) begin
                en_q  <= 1'b0;
                cnt_q <= '0;
            end else if (run && tick) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign armed     = en_q;
    assign reset_req = req_q;

    // R8/R9/R10: no advance while counting is gated off
    p_frozen_when_gated_r8: assert property (@(posedge clk) disable iff (rst)
        (en_q && !count_allowed(pwr, hold_q) && !service) |=> $stable(cnt_q));

    // R5: the reset request lasts one clock and leaves the watchdog disarmed
    p_req_single_r5: assert property (@(posedge clk) disable iff (rst)
        req_q |=> !req_q);
    p_req_disarms_r5: assert property (@(posedge clk) disable iff (rst)
        req_q |-> !en_q || $past(service));

    // R11: armed stays armed unless it expires
    p_armed_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        (en_q && !ovf_stb) |=> en_q);

    // R12: a key on the expiring tick suppresses the request
    p_service_wins_r12: assert property (@(posedge clk) disable iff (rst)
        service |=> !req_q);

endmodule

// File: rtl/wdk_pulse_gen.sv
module wdk_pulse_gen #(
    parameter int RSTOUT_LEN = 98
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  logic suppress,
    output logic pulse
);

    localparam int PW = $clog2(RSTOUT_LEN + 1);
    localparam logic [PW-1:0] LEN_V = PW'(RSTOUT_LEN);

    logic [PW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst)                    left_q <= '0;
        else if (fire && !suppress) left_q <= LEN_V;
        else if (left_q != '0)      left_q <= left_q - 1'b1;
    end

    assign pulse = (left_q != '0);

    // R6: an unsuppressed expiry loads the full pulse length
    p_pulse_load_r6: assert property (@(posedge clk) disable iff (rst)
        (fire && !suppress) |=> (left_q == LEN_V));

    // R7: a suppressed expiry starts no pulse
    p_pulse_suppressed_r7: assert property (@(posedge clk) disable iff (rst)
        (fire && suppress && !pulse) |=> !pulse);

endmodule

// File: rtl/wdk_top.sv
module wdk_top
    import wdk_pkg::*;
#(
    parameter int         CNT_W      = 14,
    parameter int         RSTOUT_LEN = 98,
    parameter logic [7:0] KEY_ADDR   = 8'hA6,
    parameter logic [7:0] KEY_FIRST  = 8'h1E,
    parameter logic [7:0] KEY_SECOND = 8'hE1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mc_tick,
    input  logic       reg_wr_en,
    input  logic [7:0] reg_wr_addr,
    input  logic [7:0] reg_wr_data,
    input  logic       pd_active,
    input  logic       idle_active,
    input  logic       wake_irq_low,
    input  logic       cfg_pause_idle,
    input  logic       cfg_rstout_off,
    output logic       wd_reset_req,
    output logic       wd_rst_out
);

    reg_wr_t  wr;
    pwr_ctx_t pwr;
    logic     service_stb;
    logic     ovf_stb;
    logic     armed;

    assign wr  = '{wr: reg_wr_en, addr: reg_wr_addr, data: reg_wr_data};
    assign pwr = '{pd: pd_active, idle: idle_active,
                   pause_idle: cfg_pause_idle, wake_low: wake_irq_low};

    wdk_key_fsm #(
        .KEY_ADDR  (KEY_ADDR),
        .KEY_FIRST (KEY_FIRST),
        .KEY_SECOND(KEY_SECOND)
    ) key_i (
        .clk        (clk),
        .rst        (rst),
        .clr        (ovf_stb),
        .wr         (wr),
        .service_stb(service_stb)
    );

    wdk_counter #(
        .CNT_W(CNT_W)
    ) cnt_i (
        .clk      (clk),
        .rst      (rst),
        .tick     (mc_tick),
        .service  (service_stb),
        .pwr      (pwr),
        .ovf_stb  (ovf_stb),
        .armed    (armed),
        .reset_req(wd_reset_req)
    );

    wdk_pulse_gen #(
        .RSTOUT_LEN(RSTOUT_LEN)
    ) pulse_i (
        .clk     (clk),
        .rst     (rst),
        .fire    (ovf_stb),
        .suppress(cfg_rstout_off),
        .pulse   (wd_rst_out)
    );

    // R1: nothing is requested while disarmed
    p_no_req_disarmed_r1: assert property (@(posedge clk) disable iff (rst)
        (!armed && !service_stb) |=> !wd_reset_req);

    // R6: the pulse and the request start together
    p_pulse_with_req_r6: assert property (@(posedge clk) disable iff (rst)
        (wd_reset_req && !$past(cfg_rstout_off)) |-> wd_rst_out);

endmodule

// File: tb/wdk_top_tb.sv
module wdk_top_tb_top;

    localparam int CW   = 6;
    localparam int PLEN = 12;
    localparam int EXP  = 1 << CW;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mc_tick = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_wr_addr = 8'h00;
    logic [7:0] reg_wr_data = 8'h00;
    logic       pd_active = 1'b0;
    logic       idle_active = 1'b0;
    logic       wake_irq_low = 1'b0;
    logic       cfg_pause_idle = 1'b0;
    logic       cfg_rstout_off = 1'b0;
    logic       wd_reset_req;
    logic       wd_rst_out;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    wdk_top #(.CNT_W(CW), .RSTOUT_LEN(PLEN)) dut_i (
        .clk(clk), .rst(rst), .mc_tick(mc_tick),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .pd_active(pd_active), .idle_active(idle_active), .wake_irq_low(wake_irq_low),
        .cfg_pause_idle(cfg_pause_idle), .cfg_rstout_off(cfg_rstout_off),
        .wd_reset_req(wd_reset_req), .wd_rst_out(wd_rst_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic arm();
        wr(8'hA6, 8'h1E);
        wr(8'hA6, 8'hE1);
    endtask

    // Issues up to n ticks; stops at the first request and measures the pulse.
    task automatic run_ticks(input int n, output int fire_idx, output int plen,
                             output bit req_long);
        fire_idx = 0; plen = 0; req_long = 1'b0;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk) mc_tick = 1'b1;
            @(negedge clk) mc_tick = 1'b0;
            if (wd_reset_req) begin
                fire_idx = i;
                while (wd_rst_out && plen < 1000) begin
                    plen++;
                    @(negedge clk);
                    if (plen == 1 && wd_reset_req) req_long = 1'b1;
                end
                if (plen == 0) begin
                    for (int k = 0; k < PLEN + 4; k++) begin
                        @(negedge clk);
                        if (k == 0 && wd_reset_req) req_long = 1'b1;
                        if (wd_rst_out) plen++;
                    end
                end
                return;
            end
        end
    endtask

    task automatic t_reset();
        int f, p; bit rl;
        do_reset();
        chk(wd_reset_req == 1'b0, "R1 req after reset", wd_reset_req, 0);
        chk(wd_rst_out == 1'b0, "R1 rst_out after reset", wd_rst_out, 0);
        run_ticks(EXP + 20, f, p, rl);
        chk(f == 0, "R1 no expiry while disarmed", f, 0);
        arm();
        run_ticks(30, f, p, rl);
        do_reset();
        run_ticks(EXP + 20, f, p, rl);
        chk(f == 0, "R1 reset disarms", f, 0);
    endtask

    task automatic t_bad_keys();
        int f, p; bit rl;
        do_reset();
        wr(8'hA6, 8'hE1);
        run_ticks(EXP + 5, f, p, rl);
        chk(f == 0, "R4 lone second byte", f, 0);
        wr(8'hA6, 8'h1E); wr(8'hA6, 8'h55); wr(8'hA6, 8'hE1);
        run_ticks(EXP + 5, f, p, rl);
        chk(f == 0, "R4 wrong byte after first", f, 0);
        wr(8'hA6, 8'h1E); wr(8'hA6, 8'h1E); wr(8'hA6, 8'hE1);
        run_ticks(EXP + 5, f, p, rl);
        chk(f == 0, "R4 doubled first byte", f, 0);
        wr(8'hA5, 8'h1E); wr(8'hA6, 8'hE1);
        run_ticks(EXP + 5, f, p, rl);
        chk(f == 0, "R4 first byte at wrong address", f, 0);
        wr(8'hA6, 8'h1E); wr(8'hA7, 8'h00); wr(8'hA6, 8'hE1);
        run_ticks(EXP + 5, f, p, rl);
        chk(f == EXP, "R2 key with foreign write between", f, EXP);
    endtask

    task automatic t_expiry();
        int f, p; bit rl;
        do_reset();
        arm();
        run_ticks(EXP + 5, f, p, rl);
        chk(f == EXP, "R2 R5 expiry tick index", f, EXP);
        chk(!rl, "R5 request is one clock", rl, 0);
        chk(p == PLEN, "R6 reset-out length", p, PLEN);
        run_ticks(EXP + 5, f, p, rl);
        chk(f == 0, "R5 disarmed after expiry", f, 0);
    endtask

    task automatic t_service();
        int f, p; bit rl;
        do_reset();
        arm();
        run_ticks(40, f, p, rl);
        arm();
        run_ticks(EXP + 5, f, p, rl);
        chk(f == EXP, "R3 restart after second key", f, EXP);
    endtask

    task automatic t_sticky();
        int f, p; bit rl;
        do_reset();
        arm();
        wr(8'hA6, 8'h00); wr(8'hA6, 8'hFF); wr(8'hA6, 8'hE1); wr(8'hA6, 8'h1E);
        run_ticks(EXP + 5, f, p, rl);
        chk(f == EXP, "R11 writes cannot disarm", f, EXP);
    endtask

    task automatic t_rstout_off();
        int f, p; bit rl;
        do_reset();
        cfg_rstout_off = 1'b1;
        arm();
        run_ticks(EXP + 5, f, p, rl);
        chk(f == EXP, "R7 request still raised", f, EXP);
        chk(p == 0, "R7 reset-out suppressed", p, 0);
        cfg_rstout_off = 1'b0;
    endtask

    task automatic t_pd();
        int f, p; bit rl;
        do_reset();
        arm();
        run_ticks(10, f, p, rl);
        @(negedge clk) pd_active = 1'b1;
        run_ticks(EXP + 5, f, p, rl);
        chk(f == 0, "R8 no count in power-down", f, 0);
        @(negedge clk) pd_active = 1'b0;
        run_ticks(EXP, f, p, rl);
        chk(f == EXP - 10, "R8 count resumes", f, EXP - 10);
    endtask

    task automatic t_wake();
        int f, p; bit rl;
        do_reset();
        arm();
        run_ticks(10, f, p, rl);
        @(negedge clk) begin pd_active = 1'b1; wake_irq_low = 1'b1; end
        run_ticks(20, f, p, rl);
        @(negedge clk) pd_active = 1'b0;
        run_ticks(EXP + 5, f, p, rl);
        chk(f == 0, "R9 frozen while wake line low", f, 0);
        @(negedge clk) wake_irq_low = 1'b0;
        @(negedge clk);
        run_ticks(EXP, f, p, rl);
        chk(f == EXP - 10, "R9 count resumes after release", f, EXP - 10);
    endtask

    task automatic t_idle();
        int f, p; bit rl;
        do_reset();
        @(negedge clk) idle_active = 1'b1;
        arm();
        run_ticks(EXP + 5, f, p, rl);
        chk(f == EXP, "R10 idle keeps counting", f, EXP);
        @(negedge clk) idle_active = 1'b0;
        cfg_pause_idle = 1'b1;
        arm();
        run_ticks(30, f, p, rl);
        @(negedge clk) idle_active = 1'b1;
        run_ticks(EXP + 5, f, p, rl);
        chk(f == 0, "R10 paused in idle", f, 0);
        @(negedge clk) idle_active = 1'b0;
        run_ticks(EXP, f, p, rl);
        chk(f == EXP - 30, "R10 resumes after idle", f, EXP - 30);
        cfg_pause_idle = 1'b0;
    endtask

    task automatic t_collide();
        int f, p; bit rl;
        do_reset();
        arm();
        run_ticks(EXP - 1, f, p, rl);
        wr(8'hA6, 8'h1E);
        @(negedge clk);
        mc_tick = 1'b1;
        reg_wr_en = 1'b1; reg_wr_addr = 8'hA6; reg_wr_data = 8'hE1;
        @(negedge clk);
        mc_tick = 1'b0; reg_wr_en = 1'b0;
        chk(wd_reset_req == 1'b0, "R12 key beats expiring tick", wd_reset_req, 0);
        @(negedge clk);
        chk(wd_reset_req == 1'b0, "R12 no late request", wd_reset_req, 0);
        run_ticks(EXP + 5, f, p, rl);
        chk(f == EXP, "R12 restart from zero", f, EXP);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        t_reset();
        t_bad_keys();
        t_expiry();
        t_service();
        t_sticky();
        t_rstout_off();
        t_pd();
        t_wake();
        t_idle();
        t_collide();
        finish_run();
    end

endmodule